// File: doc/BRIEF.md
# Wishbone Special Command Port Translator

This block is a small Wishbone slave that serves as the control port of a low-power DDR memory controller. It sits apart from the data port. A bus master writes to one of nine one-hot addresses. Each address names a special memory operation: loading the mode register, loading the extended mode register, entering or leaving power-down, deep power-down or self-refresh, or reading the status register. The port turns that write into a single command word for the controller's command interface and hands it over with a valid/ready handshake.

For the two mode-register commands, the fields in the bus data word are repacked into the row-address and bank-address form that the memory expects on a load-mode command. The other commands carry a zeroed address. The bus cycle ends in one of three ways:

- ACK, once the controller has taken the command.
- ERR, at once, for anything the port cannot translate.
- RTY, when an earlier command that its master abandoned is still waiting downstream.

Top module: `wbsc_port`

## Requirements
- R1: While reset is low and in the first cycle after it, `wb_ack_o`, `wb_err_o`, `wb_rty_o` and `cmd_valid` are low.
- R2: A write cycle whose address equals exactly one of the map values is sampled on a clock edge. From the next cycle, `cmd_valid` is high with `cmd_code` set by this map: 0x001→1 (mode register), 0x002→2 (extended mode register), 0x004→3 (power-down enter), 0x008→4 (power-down exit), 0x010→5 (deep power-down enter), 0x020→6 (deep power-down exit), 0x040→7 (self-refresh enter), 0x080→8 (self-refresh exit), 0x100→9 (status read).
- R3: For code 1, `cmd_bank` is 0 and `cmd_addr[2:0]`, `cmd_addr[3]` and `cmd_addr[6:4]` copy data bits [2:0] (burst length), [3] (burst type) and [6:4] (CAS latency). All other address bits are 0, and data bits above 6 have no effect.
- R4: For code 2, `cmd_bank` is 2'b10 and `cmd_addr[2:0]`, `[4:3]` and `[7:5]` copy data bits [2:0] (partial-array refresh), [4:3] (temperature-compensated refresh) and [7:5] (drive strength). All other address bits are 0, and data bits above 7 have no effect.
- R5: For codes 3 to 9, `cmd_bank` and `cmd_addr` are 0 whatever the data word holds.
- R6: A mode-register write whose data bits [2:0] differ from 3'b001 (a burst of two) ends with ERR in the cycle after it is sampled, and no command is issued.
- R7: A read cycle, or a write to an address outside the map, ends with ERR in the cycle after it is sampled, and no command is issued.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_code`, `cmd_bank` and `cmd_addr` hold their values.
- R9: If the bus cycle is still open on the edge where `cmd_valid` and `cmd_ready` are both high, `wb_ack_o` is high for exactly the next cycle and `cmd_valid` is low in that cycle.
- R10: A new bus cycle sampled while a command is still pending gets RTY for one cycle and issues nothing. This holds even when the pending command is accepted on that same edge.
- R11: At most one of ACK, ERR and RTY is high in any cycle, and each is a one-cycle pulse.
- R12: If the master drops CYC or STB while its command waits, the command stays presented unchanged and is delivered, and no ACK is produced for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Strobe, request valid |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADR_W (16) | One-hot command select address |
| wb_dat_i | input | DAT_W (32) | Write data carrying mode-register fields |
| wb_ack_o | output | 1 | Normal end of cycle |
| wb_err_o | output | 1 | Abnormal end of cycle |
| wb_rty_o | output | 1 | Retry, port busy |
| cmd_valid | output | 1 | Command presented downstream |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_code | output | 4 | Command code per R2 |
| cmd_bank | output | BA_W (2) | Bank address of the command |
| cmd_addr | output | MA_W (13) | Row address of the command |

## Verification
Two functions can collide in one cycle: downstream acceptance of a pending command, and the arrival of a new bus request. The bench drives both. It abandons a command, then raises a new request on the same edge that `cmd_ready` takes the pending command. It then expects RTY with no ACK and `cmd_valid` falling. It also drops the bus cycle on the very edge of acceptance and expects delivery with no ACK. Random writes, with random ready latency and noise in the ignored data bits, are compared against a bench model of the map and the field packing.

// File: rtl/wbsc_pkg.sv
// Shared types for the special command port.
// Assumes a 4-bit command code space; code 0 means "no command".
package wbsc_pkg;
    localparam int NUM_CMD = 9;
    localparam int CODE_W  = 4;

    typedef enum logic [CODE_W-1:0] {
        CMD_NONE      = 4'd0,
        CMD_MODE      = 4'd1,
        CMD_EXT_MODE  = 4'd2,
        CMD_PD_ENTER  = 4'd3,
        CMD_PD_EXIT   = 4'd4,
        CMD_DPD_ENTER = 4'd5,
        CMD_DPD_EXIT  = 4'd6,
        CMD_SR_ENTER  = 4'd7,
        CMD_SR_EXIT   = 4'd8,
        CMD_STAT_RD   = 4'd9
    } cmd_e;

    // Burst-length field code that encodes a burst of two.
    localparam logic [2:0] BL_TWO = 3'b001;
endpackage

// File: rtl/wbsc_decode.sv
// Address decoder: matches the bus address against the one-hot command
// map and decides whether the request can be translated.
// Assumes ADR_W is at least NUM_CMD bits; purely combinational.
module wbsc_decode
    import wbsc_pkg::*;
#(
    parameter int ADR_W = 16
) (
    input  logic [ADR_W-1:0] adr,
    input  logic             we,
    input  logic [2:0]       bl_field,
    output cmd_e             code,
    output logic             reject
);
    logic [NUM_CMD-1:0] hit_vec;

    // One comparator per map entry.
    for (genvar g = 0; g < NUM_CMD; g++) begin : g_hit
        assign hit_vec[g] = (adr == (ADR_W'(1) << g));
    end

    // Turn the hit vector into a command code.
    always_comb begin
        code = CMD_NONE;
        for (int i = 0; i < NUM_CMD; i++) begin
            if (hit_vec[i]) code = cmd_e'(CODE_W'(i + 1));
        end
    end

    // Read, unmapped address or an unsupported burst length all refuse.
    always_comb begin
        reject = !we || (hit_vec == '0) || (hit_vec[0] && (bl_field != BL_TWO));
    end
endmodule

// File: rtl/wbsc_pack.sv
// Field packer: places mode-register fields of the bus data into the
// row/bank address form of a load-mode command. Other commands get zero.
// Assumes MA_W >= 8 and BA_W >= 2; purely combinational.
module wbsc_pack
    import wbsc_pkg::*;
#(
    parameter int MA_W = 13,
    parameter int BA_W = 2
) (
    input  cmd_e            code,
    input  logic [7:0]      fields,
    output logic [BA_W-1:0] bank,
    output logic [MA_W-1:0] maddr
);
    localparam logic [BA_W-1:0] EXT_BANK = BA_W'(2);

    // Select bank and repack fields per command.
    always_comb begin
        bank  = '0;
        maddr = '0;
        case (code)
            CMD_MODE: begin
                maddr[2:0] = fields[2:0];   // burst length
                maddr[3]   = fields[3];     // burst type
                maddr[6:4] = fields[6:4];   // CAS latency
            end
            CMD_EXT_MODE: begin
                bank       = EXT_BANK;
                maddr[2:0] = fields[2:0];   // partial-array refresh
                maddr[4:3] = fields[4:3];   // temperature-compensated refresh
                maddr[7:5] = fields[7:5];   // drive strength
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wbsc_cmd_hold.sv
// Command holding register: presents one command downstream and keeps it
// stable until the ready/valid handshake completes.
// Assumes load is only raised while no command is pending.
module wbsc_cmd_hold
    import wbsc_pkg::*;
#(
    parameter int MA_W = 13,
    parameter int BA_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  cmd_e            code_in,
    input  logic [BA_W-1:0] bank_in,
    input  logic [MA_W-1:0] addr_in,
    input  logic            ready,
    output logic            valid,
    output cmd_e            code,
    output logic [BA_W-1:0] bank,
    output logic [MA_W-1:0] addr,
    output logic            fire
);
    assign fire = valid && ready;

    // Valid flag: set on load, cleared on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid <= 1'b0;
        else if (load)  valid <= 1'b1;
        else if (fire)  valid <= 1'b0;
    end

    // Payload: captured only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= CMD_NONE;
            bank <= '0;
            addr <= '0;
        end else if (load) begin
            code <= code_in;
            bank <= bank_in;
            addr <= addr_in;
        end
    end
endmodule

// File: rtl/wbsc_bus_resp.sv
// Bus response logic: owns the bus cycle that issued the pending command
// and produces the one-cycle ACK, ERR and RTY terminations.
// Assumes STB stays high until the cycle is terminated; a drop abandons it.
module wbsc_bus_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic reject,
    input  logic pend,
    input  logic fire,
    output logic ack,
    output logic err,
    output logic rty,
    output logic load
);
    logic own;
    logic resp_any;
    logic req_new;

    assign resp_any = ack || err || rty;
    assign req_new  = req && !own && !resp_any;
    assign load     = req_new && !pend && !reject;

    // Termination pulses, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
            err <= 1'b0;
            rty <= 1'b0;
        end else begin
            ack <= own && req && fire;
            err <= req_new && !pend && reject;
            rty <= req_new && pend;
        end
    end

    // Ownership: held while the issuing cycle is open and not yet accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)   own <= 1'b0;
        else if (own) own <= req && !fire;
        else          own <= load;
    end
endmodule

// File: rtl/wbsc_port.sv
// Special command port top: Wishbone control slave translating one-hot
// address writes into memory controller commands.
// Assumes a single clock domain and a synchronous active-low reset.
module wbsc_port
    import wbsc_pkg::*;
#(
    parameter int ADR_W = 16,
    parameter int DAT_W = 32,
    parameter int MA_W  = 13,
    parameter int BA_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_cyc_i,
    input  logic             wb_stb_i,
    input  logic             wb_we_i,
    input  logic [ADR_W-1:0] wb_adr_i,
    input  logic [DAT_W-1:0] wb_dat_i,
    output logic             wb_ack_o,
    output logic             wb_err_o,
    output logic             wb_rty_o,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [3:0]       cmd_code,
    output logic [BA_W-1:0]  cmd_bank,
    output logic [MA_W-1:0]  cmd_addr
);
    localparam int FIELD_W = 8;

    cmd_e            dec_code;
    cmd_e            held_code;
    logic            dec_reject;
    logic [BA_W-1:0] pk_bank;
    logic [MA_W-1:0] pk_addr;
    logic            load;
    logic            fire;
    logic            unused_hi;

    assign unused_hi = ^wb_dat_i[DAT_W-1:FIELD_W];

    wbsc_decode #(.ADR_W(ADR_W)) u_dec (
        .adr      (wb_adr_i),
        .we       (wb_we_i),
        .bl_field (wb_dat_i[2:0]),
        .code     (dec_code),
        .reject   (dec_reject)
    );

    wbsc_pack #(.MA_W(MA_W), .BA_W(BA_W)) u_pack (
        .code   (dec_code),
        .fields (wb_dat_i[FIELD_W-1:0]),
        .bank   (pk_bank),
        .maddr  (pk_addr)
    );

    wbsc_bus_resp u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (wb_cyc_i && wb_stb_i),
        .reject (dec_reject),
        .pend   (cmd_valid),
        .fire   (fire),
        .ack    (wb_ack_o),
        .err    (wb_err_o),
        .rty    (wb_rty_o),
        .load   (load)
    );

    wbsc_cmd_hold #(.MA_W(MA_W), .BA_W(BA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .code_in (dec_code),
        .bank_in (pk_bank),
        .addr_in (pk_addr),
        .ready   (cmd_ready),
        .valid   (cmd_valid),
        .code    (held_code),
        .bank    (cmd_bank),
        .addr    (cmd_addr),
        .fire    (fire)
    );

    assign cmd_code = held_code;
endmodule

// File: rtl/wbsc_port_chk.sv
// Protocol checker for wbsc_port, attached by bind below.
module wbsc_port_chk #(
    parameter int ADR_W = 16,
    parameter int DAT_W = 32,
    parameter int MA_W  = 13,
    parameter int BA_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_cyc_i,
    input logic             wb_stb_i,
    input logic             wb_we_i,
    input logic [ADR_W-1:0] wb_adr_i,
    input logic [DAT_W-1:0] wb_dat_i,
    input logic             wb_ack_o,
    input logic             wb_err_o,
    input logic             wb_rty_o,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [3:0]       cmd_code,
    input logic [BA_W-1:0]  cmd_bank,
    input logic [MA_W-1:0]  cmd_addr
);
    AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_ack_o, wb_err_o, wb_rty_o})); // R11
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |=> !wb_ack_o); // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err_o |=> !wb_err_o); // R11
    AST_CMD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(wb_cyc_i && wb_stb_i && wb_we_i)); // R2
    AST_MODE_BL_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 4'd1) |-> (cmd_addr[2:0] == 3'b001 && cmd_bank == '0)); // R6
    AST_POWER_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code >= 4'd3) |-> (cmd_addr == '0 && cmd_bank == '0)); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_addr) && $stable(cmd_bank))); // R8
    AST_ACK_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |-> ($past(cmd_valid && cmd_ready) && !cmd_valid)); // R9
    AST_RTY_WHEN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        wb_rty_o |-> $past(cmd_valid)); // R10
endmodule

bind wbsc_port wbsc_port_chk #(
    .ADR_W(ADR_W), .DAT_W(DAT_W), .MA_W(MA_W), .BA_W(BA_W)
) u_chk (.*);

// File: tb/wbsc_port_tb.sv
module wbsc_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [15:0] adr = '0;
    logic [31:0] dat = '0;
    logic        ack, err, rty;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [3:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    wbsc_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(dat),
        .wb_ack_o(ack), .wb_err_o(err), .wb_rty_o(rty),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic logic [3:0] exp_code(input logic [15:0] a);
        for (int i = 0; i < 9; i++) if (a == (16'd1 << i)) return 4'(i + 1);
        return 4'd0;
    endfunction

    function automatic bit exp_reject(input logic [15:0] a, input logic w, input logic [31:0] d);
        return !w || exp_code(a) == 0 || (exp_code(a) == 1 && d[2:0] != 3'b001);
    endfunction

    function automatic logic [12:0] exp_addr(input logic [3:0] c, input logic [31:0] d);
        if (c == 1) return {6'd0, d[6:4], d[3], d[2:0]};
        if (c == 2) return {5'd0, d[7:5], d[4:3], d[2:0]};
        return 13'd0;
    endfunction

    function automatic logic [1:0] exp_bank(input logic [3:0] c);
        return (c == 2) ? 2'b10 : 2'b00;
    endfunction

    // One complete bus cycle, with lat cycles of downstream back-pressure.
    task automatic bus_write(input logic [15:0] a, input logic w, input logic [31:0] d, input int lat);
        logic [3:0] c;
        string      rq;
        c = exp_code(a);
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; dat = d; cmd_ready = 0;
        @(negedge clk);
        if (exp_reject(a, w, d)) begin
            rq = (c == 1 && w) ? "R6" : "R7";
            check(err == 1, rq, "err", 32'(err), 1);
            check(cmd_valid == 0 && ack == 0, rq, "no command", 32'(cmd_valid), 0);
            cyc = 0; stb = 0;
            @(negedge clk);
            check(err == 0, "R11", "err pulse end", 32'(err), 0);
        end else begin
            check(cmd_valid == 1, "R2", "valid", 32'(cmd_valid), 1);
            check(cmd_code == c, "R2", "code", 32'(cmd_code), 32'(c));
            rq = (c == 1) ? "R3" : (c == 2) ? "R4" : "R5";
            check(cmd_addr == exp_addr(c, d), rq, "addr", 32'(cmd_addr), 32'(exp_addr(c, d)));
            check(cmd_bank == exp_bank(c), rq, "bank", 32'(cmd_bank), 32'(exp_bank(c)));
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                check(cmd_valid == 1 && cmd_code == c && cmd_addr == exp_addr(c, d) && ack == 0,
                      "R8", "held", 32'(cmd_valid), 1);
            end
            cmd_ready = 1;
            @(negedge clk);
            check(ack == 1, "R9", "ack", 32'(ack), 1);
            check(cmd_valid == 0, "R9", "valid drop", 32'(cmd_valid), 0);
            cmd_ready = 0; cyc = 0; stb = 0;
            @(negedge clk);
            check(ack == 0, "R11", "ack pulse end", 32'(ack), 0);
        end
    endtask

    // Issue a mode-register write, then abandon it while it waits.
    task automatic issue_and_abandon(input logic [31:0] d);
        @(negedge clk);
        cyc = 1; stb = 1; we = 1; adr = 16'h0001; dat = d; cmd_ready = 0;
        @(negedge clk);
        check(cmd_valid == 1, "R2", "abandon setup", 32'(cmd_valid), 1);
        cyc = 0; stb = 0;
        @(negedge clk);
        check(cmd_valid == 1 && cmd_code == 4'd1 && ack == 0, "R12", "kept after drop", 32'(cmd_valid), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(ack == 0 && err == 0 && rty == 0 && cmd_valid == 0, "R1", "reset outputs",
              {ack, err, rty, cmd_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        check(ack == 0 && err == 0 && rty == 0 && cmd_valid == 0, "R1", "after reset",
              {ack, err, rty, cmd_valid}, 0);

        // Directed: every map entry with noisy upper data bits.
        for (int i = 0; i < 9; i++) bus_write(16'd1 << i, 1'b1, 32'hA5A5_5A00 | 32'h31, i % 3);
        bus_write(16'h0002, 1'b1, 32'hFFFF_FFFF, 1);    // R4 all fields set
        bus_write(16'h0001, 1'b1, 32'hFFFF_FF81, 0);    // R3 upper noise ignored
        bus_write(16'h0001, 1'b1, 32'h0000_0032, 0);    // R6 burst length 4
        bus_write(16'h0001, 1'b1, 32'h0000_0030, 0);    // R6 burst length code 0
        bus_write(16'h0004, 1'b0, 32'h0, 0);            // R7 read cycle
        bus_write(16'h0003, 1'b1, 32'h0, 0);            // R7 two bits set
        bus_write(16'h0200, 1'b1, 32'h0, 0);            // R7 past the map
        bus_write(16'h0000, 1'b1, 32'h0, 0);            // R7 zero address

        // R10, R12: abandoned command blocks a new cycle with RTY.
        issue_and_abandon(32'h21);
        cyc = 1; stb = 1; we = 1; adr = 16'h0004;
        @(negedge clk);
        check(rty == 1 && ack == 0 && err == 0, "R10", "rty while pending", 32'(rty), 1);
        check(cmd_valid == 1 && cmd_code == 4'd1 && cmd_addr == 13'h21, "R12", "still presented",
              32'(cmd_addr), 32'h21);
        cyc = 0; stb = 0;
        @(negedge clk);
        check(rty == 0, "R11", "rty pulse end", 32'(rty), 0);
        cmd_ready = 1;
        @(negedge clk);
        check(cmd_valid == 0 && ack == 0, "R12", "delivered without ack", 32'(ack), 0);
        cmd_ready = 0;

        // R10: new request on the same edge as acceptance still retries.
        issue_and_abandon(32'h51);
        cyc = 1; stb = 1; we = 1; adr = 16'h0008; cmd_ready = 1;
        @(negedge clk);
        check(rty == 1 && ack == 0, "R10", "rty at acceptance edge", 32'(rty), 1);
        check(cmd_valid == 0, "R10", "pending accepted", 32'(cmd_valid), 0);
        cyc = 0; stb = 0; cmd_ready = 0;
        @(negedge clk);
        bus_write(16'h0008, 1'b1, 32'h0, 0);            // retry goes through

        // R12: cycle dropped on the very acceptance edge gives no ACK.
        @(negedge clk);
        cyc = 1; stb = 1; we = 1; adr = 16'h0040; dat = 32'h0;
        @(negedge clk);
        cyc = 0; stb = 0; cmd_ready = 1;
        @(negedge clk);
        check(ack == 0 && cmd_valid == 0, "R12", "drop at acceptance", {ack, cmd_valid}, 0);
        cmd_ready = 0;

        // Random mix.
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a;
            logic [31:0] d;
            logic        w;
            int          sel;
            sel = int'($urandom_range(0, 11));
            a = (sel < 9) ? (16'd1 << sel) : 16'($urandom);
            d = $urandom;
            if (sel == 0 && $urandom_range(0, 3) != 0) d[2:0] = 3'b001;
            w = ($urandom_range(0, 7) != 0);
            bus_write(a, w, d, int'($urandom_range(0, 3)));
        end

        summary();
        $finish;
    end
endmodule